// File: doc/BRIEF.md
# Counted-Loop Sequencer for a Stack Processor

This block runs the counted loops of a stack processor that executes Forth-style code. It holds two private stacks: a parameter stack with the running index and the limit of each nested loop, and a target stack with the address of the first instruction of each loop body. Subroutine return addresses are kept elsewhere, so loop data can never corrupt a return.

The processor front end presents one decoded loop opcode per clock, together with the address of that opcode. A loop opening is a single instruction that pushes its parameters and loop-back address in one step. A loop closing is a single instruction with no inline target, because the target is already on top of the target stack. On every clock the block registers the next program counter and a flag that shows a taken branch. The index and limit of the innermost loop are always visible, so other instructions can read them while the loop runs.

Top module: `loop_seq`

## Requirements
- R1: A synchronous active-high reset empties both stacks and clears the overflow and underflow flags. It also sets next_pc to 0 and br_taken to 0. With the stacks empty, loop_index and loop_limit read 0.
- R2: Opcode 1 opens a counted loop. On a stack that is not full it pushes arg_index as the index and arg_limit as the limit, and it pushes pc+1 as the loop-back address. Depth rises by one, next_pc becomes pc+1 and br_taken is 0.
- R3: Opcode 2 opens a countdown loop. On a stack that is not full it pushes arg_index as the count, with a limit of 0, and pushes pc+1 as the loop-back address. next_pc becomes pc+1.
- R4: Opcode 3 closes a counted loop. When index+1 differs from the limit, the top index becomes index+1, next_pc becomes the top loop-back address and br_taken is 1.
- R5: Opcode 3 with index+1 equal to the limit pops both stacks and sets next_pc to pc+1 with br_taken 0. The enclosing loop's index and limit become visible again.
- R6: Opcode 4 closes a countdown loop. A nonzero count is decremented and the loop branches to the top loop-back address with br_taken 1. A zero count pops both stacks and falls through to pc+1.
- R7: Opcode 5 leaves the innermost loop. It pops both stacks, and in the same clock it sets next_pc to exit_addr and br_taken to 1.
- R8: Both stacks are DEPTH entries deep, 8 by default. Opcode 1 or 2 on a full stack sets a sticky overflow flag and leaves the depth and contents unchanged. next_pc still becomes pc+1.
- R9: Opcode 3, 4 or 5 with empty stacks sets a sticky underflow flag and leaves the stacks unchanged. next_pc becomes pc+1 and br_taken is 0.
- R10: In nested loops each loop-close uses the loop-back address of the innermost loop. After the inner loop pops, the outer loop's address is used.
- R11: Opcodes 0, 6 and 7 change no stack entry and no flag. For them next_pc becomes pc+1 and br_taken is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 3 | Decoded loop opcode |
| pc | input | AW | Address of the current opcode |
| arg_index | input | DW | Start index or count operand |
| arg_limit | input | DW | Limit operand |
| exit_addr | input | AW | Continuation address for leave |
| next_pc | output | AW | Registered next program counter |
| br_taken | output | 1 | Registered taken-branch flag |
| loop_index | output | DW | Index of the innermost loop |
| loop_limit | output | DW | Limit of the innermost loop |
| loop_depth | output | $clog2(DEPTH+1) | Number of active loops |
| ovf | output | 1 | Sticky overflow flag |
| unf | output | 1 | Sticky underflow flag |

## Verification
A wrong depth pointer shows on the first loop-close after the error. That opcode either branches to a stale address or reads the wrong index, and next_pc and loop_index differ from the model one clock after the opcode. A corrupted stored index or limit shows at once on loop_index and loop_limit, and its effect on the iteration count shows at the end of that loop. Random opcode streams with short loops open, close, overflow and underflow the stacks many times. Because every cycle is compared, any divergence is caught within one clock of the opcode that exposes it.

// File: rtl/loop_seq.sv
module loop_seq #(
  parameter int DW = 16,
  parameter int AW = 16,
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH + 1),
  localparam int TW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    op,
  input  logic [AW-1:0] pc,
  input  logic [DW-1:0] arg_index,
  input  logic [DW-1:0] arg_limit,
  input  logic [AW-1:0] exit_addr,
  output logic [AW-1:0] next_pc,
  output logic          br_taken,
  output logic [DW-1:0] loop_index,
  output logic [DW-1:0] loop_limit,
  output logic [PW-1:0] loop_depth,
  output logic          ovf,
  output logic          unf
);

  localparam logic [2:0] OP_DO    = 3'd1;
  localparam logic [2:0] OP_FOR   = 3'd2;
  localparam logic [2:0] OP_LOOP  = 3'd3;
  localparam logic [2:0] OP_NEXT  = 3'd4;
  localparam logic [2:0] OP_LEAVE = 3'd5;

  logic [DW-1:0] idx_mem [DEPTH];
  logic [DW-1:0] lim_mem [DEPTH];
  logic [AW-1:0] adr_mem [DEPTH];
  logic [PW-1:0] depth;

  wire empty = (depth == '0);
  wire full  = (depth == PW'(DEPTH));
  wire [TW-1:0] top  = TW'(depth - 1'b1);
  wire [TW-1:0] slot = TW'(depth);
  wire [DW-1:0] idx_top = idx_mem[top];
  wire [DW-1:0] lim_top = lim_mem[top];
  wire [AW-1:0] adr_top = adr_mem[top];
  wire [DW-1:0] idx_inc = idx_top + 1'b1;
  wire [DW-1:0] idx_dec = idx_top - 1'b1;
  wire [AW-1:0] pc_inc  = pc + 1'b1;

  assign loop_index = empty ? '0 : idx_top;
  assign loop_limit = empty ? '0 : lim_top;
  assign loop_depth = depth;

  always_ff @(posedge clk) begin
    if (rst) begin
      depth    <= '0;
      ovf      <= 1'b0;
      unf      <= 1'b0;
      next_pc  <= '0;
      br_taken <= 1'b0;
    end else begin
      next_pc  <= pc_inc;
      br_taken <= 1'b0;
      case (op)
        OP_DO, OP_FOR: begin
          if (full) ovf <= 1'b1;
          else begin
            idx_mem[slot] <= arg_index;
            lim_mem[slot] <= (op == OP_DO) ? arg_limit : '0;
            adr_mem[slot] <= pc_inc;
            depth <= depth + 1'b1;
          end
        end
        OP_LOOP: begin
          if (empty) unf <= 1'b1;
          else if (idx_inc == lim_top) depth <= depth - 1'b1;
          else begin
            idx_mem[top] <= idx_inc;
            next_pc  <= adr_top;
            br_taken <= 1'b1;
          end
        end
        OP_NEXT: begin
          if (empty) unf <= 1'b1;
          else if (idx_top == '0) depth <= depth - 1'b1;
          else begin
            idx_mem[top] <= idx_dec;
            next_pc  <= adr_top;
            br_taken <= 1'b1;
          end
        end
        OP_LEAVE: begin
          if (empty) unf <= 1'b1;
          else begin
            depth    <= depth - 1'b1;
            next_pc  <= exit_addr;
            br_taken <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/loop_seq_chk.sv
module loop_seq_chk #(
  parameter int DW = 16,
  parameter int AW = 16,
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    op,
  input logic [AW-1:0] pc,
  input logic [AW-1:0] exit_addr,
  input logic [AW-1:0] next_pc,
  input logic          br_taken,
  input logic [DW-1:0] loop_index,
  input logic [DW-1:0] loop_limit,
  input logic [PW-1:0] loop_depth,
  input logic          ovf,
  input logic          unf
);

  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (rst)
    loop_depth <= PW'(DEPTH)); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf); // R8
  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (rst)
    unf |=> unf); // R9
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (op inside {3'd1, 3'd2}) && loop_depth == PW'(DEPTH)
    |=> ovf && loop_depth == PW'(DEPTH)); // R8
  AST_PUSH_DEPTH: assert property (@(posedge clk) disable iff (rst)
    (op inside {3'd1, 3'd2}) && loop_depth < PW'(DEPTH)
    |=> loop_depth == $past(loop_depth) + 1'b1 && !br_taken); // R2
  AST_LOOP_BRANCH: assert property (@(posedge clk) disable iff (rst)
    op == 3'd3 && loop_depth != '0 && DW'(loop_index + 1'b1) != loop_limit
    |=> br_taken && loop_index == DW'($past(loop_index) + 1'b1)); // R4
  AST_LOOP_EXIT: assert property (@(posedge clk) disable iff (rst)
    op == 3'd3 && loop_depth != '0 && DW'(loop_index + 1'b1) == loop_limit
    |=> !br_taken && loop_depth == $past(loop_depth) - 1'b1
        && next_pc == AW'($past(pc) + 1'b1)); // R5
  AST_LEAVE_PC: assert property (@(posedge clk) disable iff (rst)
    op == 3'd5 && loop_depth != '0
    |=> br_taken && next_pc == $past(exit_addr)); // R7
  AST_EMPTY_UNF: assert property (@(posedge clk) disable iff (rst)
    (op inside {3'd3, 3'd4, 3'd5}) && loop_depth == '0
    |=> unf && !br_taken && loop_depth == '0); // R9

endmodule

bind loop_seq loop_seq_chk #(.DW(DW), .AW(AW), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst(rst), .op(op), .pc(pc), .exit_addr(exit_addr),
  .next_pc(next_pc), .br_taken(br_taken), .loop_index(loop_index),
  .loop_limit(loop_limit), .loop_depth(loop_depth), .ovf(ovf), .unf(unf)
);

// File: tb/loop_seq_tb_top.sv
module loop_seq_tb_top;
  localparam int DW = 16, AW = 16, DEPTH = 8, PW = $clog2(DEPTH + 1);

  logic clk = 0, rst = 1;
  logic [2:0] op = 0;
  logic [AW-1:0] pc = 0, exit_addr = 0;
  logic [DW-1:0] arg_index = 0, arg_limit = 0;
  logic [AW-1:0] next_pc;
  logic br_taken, ovf, unf;
  logic [DW-1:0] loop_index, loop_limit;
  logic [PW-1:0] loop_depth;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [DW-1:0] m_idx [DEPTH];
  logic [DW-1:0] m_lim [DEPTH];
  logic [AW-1:0] m_adr [DEPTH];
  int m_depth;
  bit m_ovf, m_unf, e_tk;
  logic [AW-1:0] e_pc;

  always #5 clk = ~clk;

  loop_seq #(.DW(DW), .AW(AW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .op(op), .pc(pc), .arg_index(arg_index),
    .arg_limit(arg_limit), .exit_addr(exit_addr), .next_pc(next_pc),
    .br_taken(br_taken), .loop_index(loop_index), .loop_limit(loop_limit),
    .loop_depth(loop_depth), .ovf(ovf), .unf(unf));

  function automatic string tag_of(input logic [2:0] o, input int d);
    case (o)
      3'd1: return (d == DEPTH) ? "R8" : "R2";
      3'd2: return (d == DEPTH) ? "R8" : "R3";
      3'd3: return (d == 0) ? "R9" : "R4/R5";
      3'd4: return (d == 0) ? "R9" : "R6";
      3'd5: return (d == 0) ? "R9" : "R7";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "next_pc", next_pc, e_pc);
    chk(tag, "br_taken", br_taken, e_tk);
    chk(tag, "depth", loop_depth, m_depth);
    chk(tag, "ovf", ovf, m_ovf);
    chk(tag, "unf", unf, m_unf);
    chk(tag, "index", loop_index, m_depth == 0 ? 0 : m_idx[m_depth-1]);
    chk(tag, "limit", loop_limit, m_depth == 0 ? 0 : m_lim[m_depth-1]);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; op = 0;
    @(posedge clk); @(posedge clk); #1;
    m_depth = 0; m_ovf = 0; m_unf = 0; e_pc = 0; e_tk = 0;
    check_all("R1");
    @(negedge clk);
    rst = 0;
  endtask

  task automatic step(input logic [2:0] o, input logic [AW-1:0] p,
                      input logic [DW-1:0] a, input logic [DW-1:0] l,
                      input logic [AW-1:0] x);
    string tag;
    logic [DW-1:0] t;
    @(negedge clk);
    op = o; pc = p; arg_index = a; arg_limit = l; exit_addr = x;
    tag = tag_of(o, m_depth);
    e_pc = p + 1'b1; e_tk = 0;
    case (o)
      3'd1, 3'd2: if (m_depth == DEPTH) m_ovf = 1;
                  else begin
                    m_idx[m_depth] = a;
                    m_lim[m_depth] = (o == 3'd1) ? l : '0;
                    m_adr[m_depth] = p + 1'b1;
                    m_depth++;
                  end
      3'd3: if (m_depth == 0) m_unf = 1;
            else begin
              t = m_idx[m_depth-1] + 1'b1;
              if (t == m_lim[m_depth-1]) m_depth--;
              else begin m_idx[m_depth-1] = t; e_pc = m_adr[m_depth-1]; e_tk = 1; end
            end
      3'd4: if (m_depth == 0) m_unf = 1;
            else if (m_idx[m_depth-1] == 0) m_depth--;
            else begin
              m_idx[m_depth-1] = m_idx[m_depth-1] - 1'b1;
              e_pc = m_adr[m_depth-1]; e_tk = 1;
            end
      3'd5: if (m_depth == 0) m_unf = 1;
            else begin m_depth--; e_pc = x; e_tk = 1; end
      default: ;
    endcase
    @(posedge clk); #1;
    check_all(tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    do_reset();
    // R9 underflow on empty stacks, R11 no-op opcodes
    step(3'd3, 16'h0100, 0, 0, 0);
    step(3'd6, 16'h0101, 5, 5, 0);
    step(3'd7, 16'h0102, 5, 5, 0);
    step(3'd0, 16'h0103, 5, 5, 0);
    do_reset();
    // R10 nesting: outer DO 0..2 at 0x10, inner FOR 1 at 0x20
    step(3'd1, 16'h0010, 0, 2, 0);
    step(3'd2, 16'h0020, 1, 0, 0);
    step(3'd4, 16'h0030, 0, 0, 0);
    step(3'd4, 16'h0030, 0, 0, 0);
    step(3'd3, 16'h0040, 0, 0, 0);
    step(3'd3, 16'h0040, 0, 0, 0);
    // R7 leave
    step(3'd1, 16'h0050, 7, 9, 0);
    step(3'd5, 16'h0055, 0, 0, 16'h0ABC);
    // R8 overflow: nine pushes
    for (int i = 0; i < DEPTH + 1; i++) step(3'd1, AW'(16'h0200 + i), DW'(i), DW'(i + 3), 0);
    step(3'd2, 16'h0300, 4, 0, 0);
    step(3'd3, 16'h0301, 0, 0, 0);
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      int r;
      logic [2:0] o;
      logic [DW-1:0] a;
      r = $urandom % 16;
      if (r < 4) o = 3'd1; else if (r < 6) o = 3'd2; else if (r < 10) o = 3'd3;
      else if (r < 13) o = 3'd4; else if (r < 14) o = 3'd5;
      else o = (r == 14) ? 3'd6 : 3'd7;
      a = DW'($urandom % 8);
      step(o, AW'($urandom), a, a + DW'(1 + $urandom % 4), AW'($urandom));
      if (n % 700 == 699) do_reset();
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule